// File: doc/BRIEF.md
# Daisy-Chainable 24-Bit SPI Command Slave

This block is the serial front end of a programmable-resistor controller. It takes 24-bit command frames from an SPI master, most significant bit first. Each frame holds a 4-bit instruction, a 4-bit register address and a 16-bit data word. When chip-select returns high after a whole frame, the block issues a single-cycle execute strobe that carries the decoded fields to the register datapath. The datapath itself lies outside this block.

The serial output is an open-drain style pull-down. While chip-select is low it returns the bits received 24 clocks earlier, so several devices can share one chip-select and one clock in a chain. After a read instruction, the datapath's answer is loaded into the low 16 bits of the shift register, and the next frame clocks it out. All SPI pins are brought into the system clock domain through synchronizers, and the block works only on the synchronized copies.

Top module: `spi_chain_slave`

## Requirements
- R1: In a valid frame the first 4 bits received are the instruction (exec_op), the next 4 bits are the address (exec_addr) and the last 16 bits are the data word (exec_data), each field most significant bit first.
- R2: Input bits are taken only on rising edges of spi_sck while spi_cs_n is low. exec_stb is a pulse of exactly one clk cycle, and it follows the rising edge of spi_cs_n.
- R3: If the number of accepted bits when spi_cs_n rises is not a nonzero multiple of 24, no strobe is issued.
- R4: A rising edge of spi_sck that arrives while busy_lock is high shifts nothing and does not count toward the frame length.
- R5: While spi_cs_n is low, each bit presented on the serial output before a rising spi_sck edge is the bit accepted 24 accepted edges earlier. This holds across frame boundaries.
- R6: After a valid frame with instruction 9 (read stored word), the next frame shifts out that frame's instruction and address, followed by the 16-bit mem_rdata value presented during the strobe cycle.
- R7: After a valid frame with instruction 10 (read wiper), the next frame shifts out that frame's instruction and address, then six zero bits, then the 10-bit wiper_rdata value.
- R8: sdo_pull_low=1 drives the line low, which sends a 0, and sdo_pull_low=0 releases it, which reads as a 1. The output is released whenever spi_cs_n is high.
- R9: After reset, exec_stb is low, the output is released and the shift register holds zeros, so the first frame shifts out 24 zero bits.
- R10: When two devices are chained and given 48 clocks under one chip-select, the first 24 bits sent end up in the device farther down the chain, and both devices execute their own frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all logic and sampling runs on it |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, released synchronously |
| spi_sck | input | 1 | Serial clock, idle low, data taken on rising edges |
| spi_cs_n | input | 1 | Active-low chip-select that frames a transfer |
| spi_sdi | input | 1 | Serial data in |
| busy_lock | input | 1 | Synchronous lock from the datapath; serial clock edges are ignored while high |
| mem_rdata | input | 16 | Stored word for the addressed location, valid in the strobe cycle |
| wiper_rdata | input | 10 | Wiper setting for the addressed channel, valid in the strobe cycle |
| exec_stb | output | 1 | One-cycle execute strobe |
| exec_op | output | 4 | Instruction of the last valid frame |
| exec_addr | output | 4 | Address of the last valid frame |
| exec_data | output | 16 | Data word of the last valid frame |
| sdo_pull_low | output | 1 | 1 pulls the serial output low, 0 releases it |

## Verification
The assertions assume that spi_sck, spi_cs_n and spi_sdi are slow compared with clk, with each level held for more clk cycles than the synchronizer depth plus two. They also assume that busy_lock is driven synchronously to clk, and that the datapath holds mem_rdata and wiper_rdata steady through the strobe cycle and the cycle after it. The bench holds every serial clock phase for eight clk cycles. It changes the read data only while chip-select has been high long enough for any pending response load to finish, and it drives busy_lock only at falling clk edges. Random frames mix all sixteen instructions with lengths of 24, 48 and non-multiples of 24. Directed frames cover locked clock edges, short and long frames, and a two-device chain.

// File: rtl/scs_pkg.sv
package scs_pkg;
  localparam int OP_W    = 4;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 16;
  localparam int HDR_W   = OP_W + ADDR_W;
  localparam int FRAME_W = HDR_W + DATA_W;

  typedef enum logic [OP_W-1:0] {
    OP_NOP         = 4'd0,
    OP_RESTORE     = 4'd1,
    OP_SAVE_WIPER  = 4'd2,
    OP_WRITE_USER  = 4'd3,
    OP_RSHIFT_ONE  = 4'd4,
    OP_RSHIFT_ALL  = 4'd5,
    OP_DEC_ONE     = 4'd6,
    OP_DEC_ALL     = 4'd7,
    OP_RESET_ALL   = 4'd8,
    OP_READ_WORD   = 4'd9,
    OP_READ_WIPER  = 4'd10,
    OP_WRITE_WIPER = 4'd11,
    OP_LSHIFT_ONE  = 4'd12,
    OP_LSHIFT_ALL  = 4'd13,
    OP_INC_ONE     = 4'd14,
    OP_INC_ALL     = 4'd15
  } op_e;

  typedef struct packed {
    op_e               op;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/scs_sync.sv
module scs_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/scs_shifter.sv
module scs_shifter import scs_pkg::*; #(
  parameter int PH_W = $clog2(FRAME_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               sdi,
  input  logic               clear,
  input  logic               load_en,
  input  logic [FRAME_W-1:0] load_val,
  output logic [FRAME_W-1:0] sr,
  output logic [PH_W-1:0]    phase,
  output logic               full
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] sr_q, sr_d;
  logic [PH_W-1:0]    ph_q, ph_d;
  logic               full_q, full_d;

  always_comb begin
    sr_d   = sr_q;
    ph_d   = ph_q;
    full_d = full_q;
    if (load_en)       sr_d = load_val;
    else if (shift_en) sr_d = {sr_q[FRAME_W-2:0], sdi};
    if (clear) begin
      ph_d   = '0;
      full_d = 1'b0;
    end else if (shift_en) begin
      if (ph_q == LAST_PH) begin
        ph_d   = '0;
        full_d = 1'b1;
      end else begin
        ph_d = ph_q + PH_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      ph_q   <= '0;
      full_q <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      ph_q   <= ph_d;
      full_q <= full_d;
    end
  end

  assign sr    = sr_q;
  assign phase = ph_q;
  assign full  = full_q;
endmodule

// File: rtl/scs_decode.sv
module scs_decode import scs_pkg::*; #(
  parameter int PH_W = $clog2(FRAME_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_rise,
  input  logic [PH_W-1:0]    phase,
  input  logic               full,
  input  logic [FRAME_W-1:0] sr,
  output logic               stb,
  output frame_t             fr
);
  logic   frame_ok;
  logic   stb_q, stb_d;
  frame_t fr_q, fr_d;

  always_comb begin
    frame_ok = cs_rise && full && (phase == '0);
    stb_d    = frame_ok;
    fr_d     = fr_q;
    if (frame_ok) fr_d = frame_t'(sr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= 1'b0;
      fr_q  <= '0;
    end else begin
      stb_q <= stb_d;
      fr_q  <= fr_d;
    end
  end

  assign stb = stb_q;
  assign fr  = fr_q;
endmodule

// File: rtl/scs_resp.sv
module scs_resp import scs_pkg::*; #(
  parameter int WIPER_W = 10
) (
  input  logic               stb,
  input  op_e                op,
  input  logic [HDR_W-1:0]   hdr,
  input  logic [DATA_W-1:0]  word,
  input  logic [WIPER_W-1:0] wiper,
  output logic               load_en,
  output logic [FRAME_W-1:0] load_val
);
  logic [DATA_W-1:0] wiper_ext;

  generate
    if (WIPER_W < DATA_W) begin : g_pad
      assign wiper_ext = {{(DATA_W-WIPER_W){1'b0}}, wiper};
    end else begin : g_fit
      assign wiper_ext = wiper[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    load_en  = stb && ((op == OP_READ_WORD) || (op == OP_READ_WIPER));
    load_val = {hdr, (op == OP_READ_WIPER) ? wiper_ext : word};
  end
endmodule

// File: rtl/spi_chain_slave.sv
module spi_chain_slave import scs_pkg::*; #(
  parameter int WIPER_W     = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               spi_sck,
  input  logic               spi_cs_n,
  input  logic               spi_sdi,
  input  logic               busy_lock,
  input  logic [DATA_W-1:0]  mem_rdata,
  input  logic [WIPER_W-1:0] wiper_rdata,
  output logic               exec_stb,
  output logic [OP_W-1:0]    exec_op,
  output logic [ADDR_W-1:0]  exec_addr,
  output logic [DATA_W-1:0]  exec_data,
  output logic               sdo_pull_low
);
  localparam int PH_W = $clog2(FRAME_W);

  logic [2:0]         pins_q;
  logic               sck_q, cs_q, sdi_q;
  logic               sck_prev_q, sck_prev_d;
  logic               cs_prev_q, cs_prev_d;
  logic               sdo_q, sdo_d;
  logic               sck_rise, cs_rise, shift_en;
  logic [FRAME_W-1:0] sr;
  logic [PH_W-1:0]    phase;
  logic               full;
  logic               load_en;
  logic [FRAME_W-1:0] load_val;
  frame_t             fr;

  scs_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({spi_sck, spi_cs_n, spi_sdi}),
    .q     (pins_q)
  );

  assign sck_q = pins_q[2];
  assign cs_q  = pins_q[1];
  assign sdi_q = pins_q[0];

  always_comb begin
    sck_prev_d = sck_q;
    cs_prev_d  = cs_q;
    sck_rise   = sck_q && !sck_prev_q;
    cs_rise    = cs_q && !cs_prev_q;
    shift_en   = sck_rise && !cs_q && !busy_lock;
    sdo_d      = !cs_q && !sr[FRAME_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev_q <= 1'b0;
      cs_prev_q  <= 1'b1;
      sdo_q      <= 1'b0;
    end else begin
      sck_prev_q <= sck_prev_d;
      cs_prev_q  <= cs_prev_d;
      sdo_q      <= sdo_d;
    end
  end

  scs_shifter #(.PH_W(PH_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .sdi      (sdi_q),
    .clear    (cs_q),
    .load_en  (load_en),
    .load_val (load_val),
    .sr       (sr),
    .phase    (phase),
    .full     (full)
  );

  scs_decode #(.PH_W(PH_W)) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_rise (cs_rise),
    .phase   (phase),
    .full    (full),
    .sr      (sr),
    .stb     (exec_stb),
    .fr      (fr)
  );

  scs_resp #(.WIPER_W(WIPER_W)) u_resp (
    .stb      (exec_stb),
    .op       (fr.op),
    .hdr      (sr[FRAME_W-1:DATA_W]),
    .word     (mem_rdata),
    .wiper    (wiper_rdata),
    .load_en  (load_en),
    .load_val (load_val)
  );

  assign exec_op      = fr.op;
  assign exec_addr    = fr.addr;
  assign exec_data    = fr.data;
  assign sdo_pull_low = sdo_q;
endmodule

// File: rtl/spi_chain_slave_chk.sv
module spi_chain_slave_chk import scs_pkg::*; #(
  parameter int WIPER_W = 10,
  parameter int PH_W    = $clog2(FRAME_W)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               spi_cs_n,
  input logic               busy_lock,
  input logic               cs_q,
  input logic [PH_W-1:0]    phase,
  input logic               full,
  input logic [FRAME_W-1:0] sr,
  input logic               exec_stb,
  input logic [OP_W-1:0]    exec_op,
  input logic [DATA_W-1:0]  mem_rdata,
  input logic [WIPER_W-1:0] wiper_rdata,
  input logic               sdo_pull_low
);
  p_sdo_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3) && $past(spi_cs_n, 4))
      |-> !sdo_pull_low);

  p_stb_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    exec_stb |=> !exec_stb);

  p_stb_whole_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    exec_stb |-> ($past(phase) == '0) && $past(full));

  p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_lock && !cs_q) |=> ($stable(phase) && $stable(full)));

  p_word_resp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_stb && exec_op == 4'd9) |=> (sr[DATA_W-1:0] == $past(mem_rdata)));

  p_wiper_resp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_stb && exec_op == 4'd10) |=> (sr[DATA_W-1:0] == DATA_W'($past(wiper_rdata))));
endmodule

bind spi_chain_slave spi_chain_slave_chk #(.WIPER_W(WIPER_W), .PH_W(PH_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .spi_cs_n     (spi_cs_n),
  .busy_lock    (busy_lock),
  .cs_q         (cs_q),
  .phase        (phase),
  .full         (full),
  .sr           (sr),
  .exec_stb     (exec_stb),
  .exec_op      (exec_op),
  .mem_rdata    (mem_rdata),
  .wiper_rdata  (wiper_rdata),
  .sdo_pull_low (sdo_pull_low)
);

// File: tb/tb_spi_chain_slave.sv
module tb_spi_chain_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0;
  logic cs_n = 1'b1;
  logic sdi = 1'b0;
  logic busy = 1'b0;
  logic [15:0] mem_rdata = 16'h0;
  logic [9:0]  wiper_rdata = 10'h0;

  logic        stb_u, stb_d, sdo_u, sdo_d;
  logic [3:0]  op_u, op_d, ad_u, ad_d;
  logic [15:0] da_u, da_d;
  logic        dn_sdi;

  int checks = 0;
  int errors = 0;
  int n_stb_u = 0;
  int n_stb_d = 0;
  logic [23:0] cap_u, cap_d;
  logic [23:0] m_up = 24'h0;
  logic [23:0] m_dn = 24'h0;
  string out_tag = "R9";

  always #(CLK_PERIOD/2) clk = ~clk;

  assign dn_sdi = ~sdo_u;

  spi_chain_slave dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_sdi(sdi),
    .busy_lock(busy), .mem_rdata(mem_rdata), .wiper_rdata(wiper_rdata),
    .exec_stb(stb_u), .exec_op(op_u), .exec_addr(ad_u), .exec_data(da_u),
    .sdo_pull_low(sdo_u));

  spi_chain_slave dut_down (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_sdi(dn_sdi),
    .busy_lock(1'b0), .mem_rdata(mem_rdata), .wiper_rdata(wiper_rdata),
    .exec_stb(stb_d), .exec_op(op_d), .exec_addr(ad_d), .exec_data(da_d),
    .sdo_pull_low(sdo_d));

  always @(negedge clk) begin
    if (stb_u) begin n_stb_u <= n_stb_u + 1; cap_u <= {op_u, ad_u, da_u}; end
    if (stb_d) begin n_stb_d <= n_stb_d + 1; cap_d <= {op_d, ad_d, da_d}; end
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [23:0] respond(input logic [23:0] fr);
    if (fr[23:20] == 4'd9)  return {fr[23:16], mem_rdata};
    if (fr[23:20] == 4'd10) return {fr[23:16], 6'b0, wiper_rdata};
    return fr;
  endfunction

  // Sends n bits from the low end of bits, MSB first; busy held on bits blo..bhi
  task automatic send(input logic [47:0] bits, input int n, input int blo, input int bhi, input string tag);
    int s0u = n_stb_u;
    int s0d = n_stb_d;
    int acc_u = 0;
    bit exp_u, exp_d;
    logic [23:0] pre_u, pre_d;
    cs_n = 1'b0;
    wait_clk(HALF_BIT);
    for (int k = 0; k < n; k++) begin
      logic b, ob, bz;
      b  = bits[n-1-k];
      bz = (k >= blo) && (k <= bhi);
      sdi = b; sck = 1'b0; busy = bz;
      wait_clk(HALF_BIT);
      ob = m_up[23];
      check(sdo_u == ~ob, out_tag, {31'h0, sdo_u}, {31'h0, ~ob});
      sck = 1'b1;
      wait_clk(HALF_BIT);
      m_dn = {m_dn[22:0], ob};
      if (!bz) begin m_up = {m_up[22:0], b}; acc_u++; end
    end
    busy = 1'b0; sck = 1'b0;
    wait_clk(4);
    cs_n = 1'b1;
    wait_clk(24);
    exp_u = (acc_u > 0) && (acc_u % 24 == 0);
    exp_d = (n > 0) && (n % 24 == 0);
    check((n_stb_u - s0u) == (exp_u ? 1 : 0), tag, n_stb_u - s0u, exp_u ? 1 : 0);
    check((n_stb_d - s0d) == (exp_d ? 1 : 0), "R10", n_stb_d - s0d, exp_d ? 1 : 0);
    check(sdo_u == 1'b0, "R8", {31'h0, sdo_u}, 0);
    pre_u = m_up; pre_d = m_dn;
    out_tag = "R5";
    if (exp_u) begin
      check(cap_u == pre_u, "R1", {8'h0, cap_u}, {8'h0, pre_u});
      m_up = respond(pre_u);
      if (pre_u[23:20] == 4'd9)  out_tag = "R6";
      if (pre_u[23:20] == 4'd10) out_tag = "R7";
    end
    if (exp_d) begin
      check(cap_d == pre_d, "R10", {8'h0, cap_d}, {8'h0, pre_d});
      m_dn = respond(pre_d);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    wait_clk(5);
    check(stb_u == 1'b0, "R9", {31'h0, stb_u}, 0);
    check(sdo_u == 1'b0, "R9", {31'h0, sdo_u}, 0);
    rst_n = 1'b1;
    wait_clk(5);
    check(stb_u == 1'b0 && sdo_u == 1'b0, "R9", {30'h0, stb_u, sdo_u}, 0);
    mem_rdata = 16'hA5C3; wiper_rdata = 10'h2B7;
    send(48'hB0_0155, 24, -1, -1, "R2");          // write wiper, shifts out zeros (R9)
    send(48'h93_1234, 24, -1, -1, "R2");          // read stored word (R6)
    mem_rdata = 16'h1111;
    send(48'hA1_0000, 24, -1, -1, "R2");          // read wiper (R7)
    send(48'h00_0000, 24, -1, -1, "R2");
    send(48'h7F_FFFF, 23, -1, -1, "R3");          // short frame
    send(48'h1ABCDEF, 25, -1, -1, "R3");          // long frame
    send(48'h5A5A5A5, 27, 5, 7, "R4");            // 3 locked edges -> 24 accepted
    send(48'hE2_3344, 24, 0, 23, "R4");           // all edges locked -> discarded
    send(48'h61_2222_C5_9999, 48, -1, -1, "R10"); // two-device chain
    for (int i = 0; i < 40; i++) begin
      int r, n;
      logic [47:0] w;
      r = $urandom_range(0, 9);
      n = (r < 7) ? 24 : (r == 7) ? 48 : $urandom_range(1, 30);
      w = {$urandom(), $urandom()};
      mem_rdata = 16'($urandom());
      wiper_rdata = 10'($urandom());
      send(w, n, -1, -1, "R2");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule